// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block checks one 512-byte sector read from flash. It compares the 24-bit parity code that was stored in the spare area with the 24-bit code that was computed again over the same data. It decides whether the sector is clean, holds exactly one flipped data bit that can be repaired, or cannot be repaired. For the repairable case it names the byte and the bit to invert. It can then repair that byte in a sector buffer through a read/modify/write port.

The two codes are first mapped into a 24-bit syndrome layout. In that layout even positions hold the "even" parity terms and odd positions hold the "odd" terms, from the finest grouping to the coarsest. The block classifies the XOR of the two mapped codes by its population count. The odd positions of that syndrome spell out the byte offset and the bit index.

A sector that was never written reads back all-ones data. Its stored code is all ones, while the code computed over it is all zeros. The block reports such a sector as clean and does not flag it.

Top module: `ecc_sector_fixer`

## Requirements
- R1: When `stored_code` equals `calc_code`, `status` becomes 2'b00 (clean) one cycle after an accepted `start`. In that same cycle `done` pulses, `fix_valid` stays low and the buffer is not touched.
- R2: When the XOR of the two codes has exactly 12 ones, `status` becomes 2'b01 (corrected) one cycle after `start`, and `fix_valid` pulses for that one cycle only.
- R3: Code layout: bits [7:0] hold the even terms 0..7, bits [15:8] the odd terms 0..7, bits [19:16] the even terms 8..11 and bits [23:20] the odd terms 8..11. Call the XOR of the two codes `d`. In the corrected case `fix_byte` = {d[23:20], d[15:11]} and `fix_bit` = d[10:8].
- R4: A difference with exactly 1 one (a fault in the code itself) or exactly 11 ones gives `status` 2'b10 (uncorrectable), with `fix_valid` low and `done` one cycle after `start`.
- R5: Any nonzero difference whose count of ones is not 12 gives 2'b10, except for the erased case of R6.
- R6: When `stored_code` is 24'hFFFFFF and `calc_code` is 24'h000000, the status is 2'b00 (erased sector). When `stored_code` is all ones but `calc_code` is some other value, R5 applies.
- R7: For a corrected sector, `buf_rd_en` is high with `buf_addr` = `fix_byte` one cycle after `start`. Read data is expected in the following cycle. Two cycles after the read request, `buf_wr_en` and `done` are high together, with `buf_wdata` = read byte XOR (1 << `fix_bit`).
- R8: A `start` that arrives while a buffer repair is in progress is ignored. The status, the fix fields and the repair sequence are not changed by it.
- R9: After reset, `status` is 2'b00 and `fix_valid`, `done`, `buf_rd_en` and `buf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Evaluate the two codes this cycle |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the sector data |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| fix_byte | output | 9 | Byte offset of the flipped bit |
| fix_bit | output | 3 | Bit index inside that byte |
| fix_valid | output | 1 | One-cycle pulse when a correction is reported |
| done | output | 1 | One-cycle pulse when the sector is finished |
| buf_rd_en | output | 1 | Sector buffer read request |
| buf_wr_en | output | 1 | Sector buffer write request |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wdata | output | 8 | Repaired byte to write |
| buf_rdata | input | 8 | Byte read, valid the cycle after `buf_rd_en` |

## Verification
The status, the fix fields and `fix_valid` are due one cycle after the `start` edge. For sectors that are not repaired, `done` is also due in that cycle. For a repaired sector, the read request is due in that same cycle, the write together with `done` two cycles later, and the updated buffer byte one cycle after that. The bench drives its inputs on falling edges and samples each of these outputs on the falling edge of exactly the cycle in which it is due. It also checks that the neighbouring cycles are quiet. Expected classes are computed from the count of ones in the raw code difference, and expected addresses are taken directly from the code fields.

// File: rtl/ecc_fix_pkg.sv
// Package: shared status type and a bit-count helper for the sector
// corrector. Assumes a 2-bit status encoding that is visible at the ports.
package ecc_fix_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_FIXED  = 2'b01,
        ST_UNCORR = 2'b10
    } fix_status_t;

    // Count the ones in a 24-bit vector.
    function automatic logic [4:0] ones24(input logic [23:0] v);
        logic [4:0] n;
        n = '0;
        for (int i = 0; i < 24; i++) begin
            n = n + {4'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/ecc_parity_reorder.sv
// Module: maps a packed 24-bit parity code into syndrome order.
// Even parity term k goes to bit 2k and odd term k goes to bit 2k+1.
// Assumes the packed layout: terms 0..7 in the low two bytes (even, then
// odd), and terms 8..11 in the low (even) and high (odd) nibbles of the
// top byte. This layout only holds for PAR_W = 12.
module ecc_parity_reorder #(
    parameter int PAR_W = 12
) (
    input  logic [2*PAR_W-1:0] packed_code,
    output logic [2*PAR_W-1:0] ordered
);
    localparam int LOW_TERMS = 8;

    for (genvar k = 0; k < PAR_W; k++) begin : g_term
        if (k < LOW_TERMS) begin : g_low
            assign ordered[2*k]   = packed_code[k];
            assign ordered[2*k+1] = packed_code[LOW_TERMS + k];
        end else begin : g_high
            assign ordered[2*k]   = packed_code[2*LOW_TERMS + (k - LOW_TERMS)];
            assign ordered[2*k+1] = packed_code[2*LOW_TERMS + 4 + (k - LOW_TERMS)];
        end
    end

endmodule

// File: rtl/ecc_syndrome_classify.sv
// Module: combinational classification of a stored/calculated code pair.
// It reorders both codes, XORs them into a syndrome, counts the ones and
// picks clean / corrected / uncorrectable. It also extracts the byte offset
// and the bit index from the odd syndrome positions.
// Assumes 24-bit codes (12 parity terms for a 512-byte sector).
module ecc_syndrome_classify
    import ecc_fix_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANE_W = 3
) (
    input  logic [2*(ADDR_W+LANE_W)-1:0] stored_code,
    input  logic [2*(ADDR_W+LANE_W)-1:0] calc_code,
    output fix_status_t                  cls,
    output logic [ADDR_W-1:0]            byte_off,
    output logic [LANE_W-1:0]            bit_idx
);
    localparam int PAR_W  = ADDR_W + LANE_W;
    localparam int CODE_W = 2 * PAR_W;
    localparam int SINGLE = PAR_W;

    logic [CODE_W-1:0] ord [2];
    logic [CODE_W-1:0] syn;
    logic [4:0]        syn_ones;

    // Two identical reorder instances, one per code.
    for (genvar c = 0; c < 2; c++) begin : g_ord
        ecc_parity_reorder #(.PAR_W(PAR_W)) u_ord (
            .packed_code (c == 0 ? stored_code : calc_code),
            .ordered     (ord[c])
        );
    end

    assign syn      = ord[0] ^ ord[1];
    assign syn_ones = ones24(syn);

    // Byte offset and bit index come from the odd syndrome positions.
    for (genvar j = 0; j < LANE_W; j++) begin : g_bit
        assign bit_idx[j] = syn[2*j+1];
    end
    for (genvar j = 0; j < ADDR_W; j++) begin : g_byte
        assign byte_off[j] = syn[2*(j+LANE_W)+1];
    end

    // Order of decision: identical, single-bit pattern, erased sector, rest.
    always_comb begin
        if (stored_code == calc_code) begin
            cls = ST_CLEAN;
        end else if (syn_ones == 5'(SINGLE)) begin
            cls = ST_FIXED;
        end else if (&stored_code && ord[1] == '0) begin
            cls = ST_CLEAN;
        end else begin
            cls = ST_UNCORR;
        end
    end

endmodule

// File: rtl/ecc_fix_sequencer.sv
// Module: registers the classification on an accepted start. When USE_BUF
// is set and the sector can be repaired, it runs a read, modify and write
// of one byte in the sector buffer. Assumes buf_rdata is valid in the cycle
// after buf_rd_en. A start is accepted only in the idle state.
module ecc_fix_sequencer
    import ecc_fix_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int LANE_W  = 3,
    parameter bit USE_BUF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  fix_status_t       cls,
    input  logic [ADDR_W-1:0] byte_off,
    input  logic [LANE_W-1:0] bit_idx,
    output fix_status_t       status,
    output logic [ADDR_W-1:0] fix_byte,
    output logic [LANE_W-1:0] fix_bit,
    output logic              fix_valid,
    output logic              done,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    localparam int LANES = 1 << LANE_W;

    typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE, S_WRITE} seq_t;

    seq_t             state;
    logic             accept;
    logic             busy;
    logic             rd_q, wr_q;
    logic [LANES-1:0] wdata_q;
    logic [LANES-1:0] flip_mask;

    assign busy      = (state != S_IDLE);
    assign accept    = start && !busy;
    assign flip_mask = LANES'(1) << fix_bit;

    // Result registers and the repair state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            status    <= ST_CLEAN;
            fix_byte  <= '0;
            fix_bit   <= '0;
            fix_valid <= 1'b0;
            done      <= 1'b0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            fix_valid <= 1'b0;
            done      <= 1'b0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        status    <= cls;
                        fix_valid <= (cls == ST_FIXED);
                        fix_byte  <= (cls == ST_FIXED) ? byte_off : '0;
                        fix_bit   <= (cls == ST_FIXED) ? bit_idx  : '0;
                        if (cls == ST_FIXED && USE_BUF) begin
                            rd_q  <= 1'b1;
                            state <= S_READ;
                        end else begin
                            done  <= 1'b1;
                        end
                    end
                end
                S_READ:  state <= S_MERGE;
                S_MERGE: begin
                    wdata_q <= buf_rdata ^ flip_mask;
                    wr_q    <= 1'b1;
                    done    <= 1'b1;
                    state   <= S_WRITE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Either expose the buffer port or tie it off.
    if (USE_BUF) begin : g_buf
        assign buf_rd_en = rd_q;
        assign buf_wr_en = wr_q;
        assign buf_addr  = fix_byte;
        assign buf_wdata = wdata_q;
    end else begin : g_nobuf
        assign buf_rd_en = 1'b0;
        assign buf_wr_en = 1'b0;
        assign buf_addr  = '0;
        assign buf_wdata = '0;
    end

    // R2: a correction pulse only accompanies a corrected status
    a_r2_valid_means_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> status == ST_FIXED);

    // R1: an accepted start finishes or starts a repair on the next cycle
    a_r1_answer_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (done || buf_rd_en));

    // R7: a read request is followed by a write two cycles later
    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> ##1 (buf_wr_en && done));

    // R7: the written byte differs from the byte read in exactly one bit
    a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $countones(buf_wdata ^ $past(buf_rdata)) == 1);

    // R8: results hold steady while a repair is running
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(status) && $stable(fix_byte) && $stable(fix_bit)));

endmodule

// File: rtl/ecc_sector_fixer.sv
// Module: top of the sector corrector. It joins the combinational
// classifier to the result and repair sequencer. Assumes 512-byte sectors
// and 24-bit codes. One sector is handled at a time.
module ecc_sector_fixer #(
    parameter int SECTOR_BYTES = 512,
    parameter bit USE_BUF      = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [23:0] stored_code,
    input  logic [23:0] calc_code,
    output logic [1:0]  status,
    output logic [8:0]  fix_byte,
    output logic [2:0]  fix_bit,
    output logic        fix_valid,
    output logic        done,
    output logic        buf_rd_en,
    output logic        buf_wr_en,
    output logic [8:0]  buf_addr,
    output logic [7:0]  buf_wdata,
    input  logic [7:0]  buf_rdata
);
    import ecc_fix_pkg::*;

    localparam int ADDR_W = $clog2(SECTOR_BYTES);
    localparam int LANE_W = 3;

    fix_status_t       cls;
    fix_status_t       status_q;
    logic [ADDR_W-1:0] byte_off;
    logic [LANE_W-1:0] bit_idx;

    ecc_syndrome_classify #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_cls (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .cls         (cls),
        .byte_off    (byte_off),
        .bit_idx     (bit_idx)
    );

    ecc_fix_sequencer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .USE_BUF(USE_BUF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cls       (cls),
        .byte_off  (byte_off),
        .bit_idx   (bit_idx),
        .status    (status_q),
        .fix_byte  (fix_byte),
        .fix_bit   (fix_bit),
        .fix_valid (fix_valid),
        .done      (done),
        .buf_rd_en (buf_rd_en),
        .buf_wr_en (buf_wr_en),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .buf_rdata (buf_rdata)
    );

    assign status = status_q;

    // R4: the status code 2'b11 is never produced
    a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    // R7: the buffer is never read and written in the same cycle
    a_r7_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

endmodule

// File: tb/ecc_sector_fixer_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random code pairs. It models a
// 512-byte sector buffer with one cycle of read latency.
module ecc_sector_fixer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic [1:0]  status;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;
    logic        fix_valid, done, buf_rd_en, buf_wr_en;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  mem [512];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ecc_sector_fixer uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .status(status), .fix_byte(fix_byte), .fix_bit(fix_bit),
        .fix_valid(fix_valid), .done(done),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // Sector buffer model: registered read, write on the clock edge.
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected class from the raw difference (a permutation keeps the count).
    function automatic logic [1:0] exp_status(input logic [23:0] s, input logic [23:0] c);
        logic [23:0] d;
        d = s ^ c;
        if (d == 24'h0) return 2'b00;
        if ($countones(d) == 12) return 2'b01;
        if (s == 24'hFFFFFF && c == 24'h0) return 2'b00;
        return 2'b10;
    endfunction

    // Build a single-bit-error difference for a given byte and bit.
    function automatic logic [23:0] fix_diff(input logic [8:0] b, input logic [2:0] k);
        logic [11:0] o, e;
        o = {b, k};
        e = ~o;
        return {o[11:8], e[11:8], o[7:0], e[7:0]};
    endfunction

    // Run one sector and check every output in the cycle it is due.
    task automatic run(input logic [23:0] s, input logic [23:0] c, input string tag);
        logic [1:0]  es;
        logic [23:0] d;
        logic [8:0]  eb;
        logic [2:0]  ek;
        logic [7:0]  orig;
        es = exp_status(s, c);
        d  = s ^ c;
        eb = {d[23:20], d[15:11]};
        ek = d[10:8];
        @(negedge clk);
        stored_code = s; calc_code = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1/R4/R5/R6 status"}, status, es);
        chk({tag, " R2 fix_valid"}, fix_valid, es == 2'b01);
        if (es == 2'b01) begin
            chk({tag, " R3 fix_byte"}, fix_byte, eb);
            chk({tag, " R3 fix_bit"}, fix_bit, ek);
            chk({tag, " R7 read request"}, {buf_rd_en, buf_addr}, {1'b1, eb});
            chk({tag, " R7 no early done"}, done, 0);
            orig = mem[eb];
            @(negedge clk);
            chk({tag, " R2 pulse length"}, fix_valid, 0);
            chk({tag, " R7 quiet gap"}, {buf_rd_en, buf_wr_en, done}, 0);
            @(negedge clk);
            chk({tag, " R7 write"}, {buf_wr_en, done, buf_addr}, {2'b11, eb});
            chk({tag, " R7 wdata"}, buf_wdata, orig ^ (8'h1 << ek));
            @(negedge clk);
            chk({tag, " R7 buffer updated"}, mem[eb], orig ^ (8'h1 << ek));
            chk({tag, " R7 done pulse"}, done, 0);
        end else begin
            chk({tag, " R1 done"}, done, 1);
            chk({tag, " R1 no buffer access"}, {buf_rd_en, buf_wr_en}, 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] c;
        void'($urandom(32'd4711));
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {status, fix_valid, done, buf_rd_en, buf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {status, fix_valid, done, buf_rd_en, buf_wr_en}, 0);

        // Directed corners.
        run(24'h123456, 24'h123456, "R1 identical");
        run(24'hA5A5A5 ^ fix_diff(9'd0, 3'd0), 24'hA5A5A5, "R2 byte0 bit0");
        run(24'h0F0F0F ^ fix_diff(9'd511, 3'd7), 24'h0F0F0F, "R3 last byte bit7");
        run(24'h000FFF, 24'h000000, "R3 non-complement twelve");
        run(24'h000001, 24'h000000, "R4 one code bit");
        run(24'h0007FF, 24'h000000, "R4 eleven ones");
        run(24'h00000F, 24'h000000, "R5 four ones");
        run(24'hFFFFFF, 24'h000000, "R6 erased");
        run(24'hFFFFFF, 24'h000010, "R6 all-ones stored, nonzero calc");

        // R8: a second start during a repair is ignored.
        @(negedge clk);
        stored_code = 24'h333333 ^ fix_diff(9'd77, 3'd2); calc_code = 24'h333333; start = 1'b1;
        @(negedge clk);
        stored_code = 24'h000001; calc_code = 24'h000000;
        @(negedge clk);
        start = 1'b0;
        chk("R8 status held", status, 2'b01);
        chk("R8 fix_byte held", fix_byte, 9'd77);
        chk("R8 no extra done", done, 0);
        @(negedge clk);
        chk("R8 repair continues", {buf_wr_en, done, buf_addr}, {2'b11, 9'd77});
        @(negedge clk);
        chk("R8 back to idle quiet", {done, fix_valid}, 0);

        // Seeded random mix.
        for (int t = 0; t < 60; t++) begin
            int kind;
            c = 24'($urandom);
            kind = $urandom % 4;
            case (kind)
                0: run(c, c, "R1 random same");
                1: run(c ^ fix_diff(9'($urandom), 3'($urandom)), c, "R2 random single");
                2: run(c ^ (($urandom % 2) ? (24'h1 << ($urandom % 24)) : 24'h7FF000), c, "R4 random");
                default: run(24'($urandom), c, "R5 random");
            endcase
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule